// File: doc/BRIEF.md
# Serial Grayscale Shift Register with Routed Latch

This block receives a long serial word for an LED driver and hands it to one of two storage targets. Serial bits arrive on a slow shift clock and pass along a 288-bit chain whose top bit is always visible on the serial output. When a separate load strobe rises, the chain contents are copied into one of two targets. The first target is the grayscale store, which takes the whole chain. The second is a configuration copy, which is split between a 199-bit configuration latch and the upper part of a 216-bit configuration shift register.

The strobe level seen at the most recent shift-clock edge picks the target. A remembered low selects the grayscale store. A remembered high selects the configuration copy. The grayscale store is shown as 24 channel values of 12 bits each, and a new value appears on them in the cycle the copy is made. All logic runs on one fast system clock. The shift clock and the strobe are synchronized with two flops each, and their rising edges are found from the synchronized samples. A warning pulse marks any grayscale load that happens while the blank status input is high.

Top module: `led_shift_router`

## Requirements
- R1: After reset, the serial output, the warning flag, every channel value, the configuration latch and the configuration shift register all read zero.
- R2: On each synchronized rising edge of the shift clock, the serial input enters bit 0 and every chain bit moves up one place. The serial output always shows bit 287, so the first bit shifted in appears on it after 288 shifts.
- R3: The target of a load is set by the strobe level at the most recent shift-clock rising edge. Strobe changes between shift edges do not alter that choice.
- R4: A strobe rising edge with a remembered low copies all 288 chain bits into the grayscale store and leaves both configuration targets unchanged.
- R5: A strobe rising edge with a remembered high copies chain bits 0 to 198 into bits 0 to 198 of the configuration latch and leaves the grayscale store unchanged.
- R6: In the same high case, chain bits 199 to 215 are copied into bits 199 to 215 of the configuration shift register. Its bits 0 to 198 are not written by this block and read zero.
- R7: Channel k (k = 0..23, in the order R0, G0, B0, R1, ... B7) shows grayscale store bits 12k+11 down to 12k, with bit 12k+11 as its MSB.
- R8: The warning flag pulses high for exactly one cycle, together with the new channel values, after a grayscale load made while blank is high. Configuration loads and loads with blank low do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Asynchronous shift clock |
| ser_din_i | input | 1 | Serial data input |
| strobe_i | input | 1 | Asynchronous load strobe |
| blank_i | input | 1 | Blank status input |
| ser_dout_o | output | 1 | Serial data output (chain bit 287) |
| gs_chan_o | output | 24x12 | Channel grayscale values, index = channel |
| cfg_lat_o | output | 199 | Configuration latch |
| cfg_sr_o | output | 216 | Configuration shift register |
| gs_warn_o | output | 1 | Grayscale load made while blank was high |

## Verification
The assertions follow every cycle. They check that the chain moves by exactly one place on a shift event and holds otherwise, that the remembered strobe level is refreshed only on shift events, and that each load goes to exactly one target with that target matching the chain as it was. They also check that the untouched targets hold and that the warning follows a grayscale load made under blank. What the assertions cannot show is the end-to-end behaviour seen at the pins: the order in which bits leave on the serial output, the mapping of chain bits to named channels, and how target selection behaves when the strobe rises partway through a transfer. The bench scenarios demonstrate these against an independent model.

// File: rtl/led_sr_pkg.sv
package led_sr_pkg;
  // lowest chain bit of a channel field
  function automatic int field_lsb(input int ch, input int width);
    return ch * width;
  endfunction

  // channel count of a chain of given length
  function automatic int chan_count(input int len, input int width);
    return len / width;
  endfunction
endpackage

// File: rtl/led_edge_sync.sv
module led_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [2:0] stg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[1:0], async_i};
  end

  assign level_o = stg_q[1];
  assign rise_o  = stg_q[1] & ~stg_q[2];
endmodule

// File: rtl/led_shift_core.sv
module led_shift_core #(
  parameter int SR_LEN = 288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_evt_i,
  input  logic              din_i,
  input  logic              strobe_lvl_i,
  output logic [SR_LEN-1:0] chain_o,
  output logic              sel_o
);
  logic [SR_LEN-1:0] chain_q;
  logic              sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      sel_q   <= 1'b0;
    end else if (shift_evt_i) begin
      chain_q <= {chain_q[SR_LEN-2:0], din_i};
      sel_q   <= strobe_lvl_i;
    end
  end

  assign chain_o = chain_q;
  assign sel_o   = sel_q;
endmodule

// File: rtl/led_latch_router.sv
module led_latch_router #(
  parameter int SR_LEN      = 288,
  parameter int CFG_LAT_LEN = 199,
  parameter int CFG_SR_LEN  = 216
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  gs_evt_i,
  input  logic                  cfg_evt_i,
  input  logic                  blank_i,
  input  logic [SR_LEN-1:0]     chain_i,
  output logic [SR_LEN-1:0]     gs_o,
  output logic [CFG_LAT_LEN-1:0] cfg_lat_o,
  output logic [CFG_SR_LEN-1:0] cfg_sr_o,
  output logic                  warn_o
);
  localparam int UPPER_W = CFG_SR_LEN - CFG_LAT_LEN;

  logic [SR_LEN-1:0]      gs_q;
  logic [CFG_LAT_LEN-1:0] lat_q;
  logic [UPPER_W-1:0]     upper_q;
  logic                   warn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gs_q    <= '0;
      lat_q   <= '0;
      upper_q <= '0;
      warn_q  <= 1'b0;
    end else begin
      warn_q <= gs_evt_i & blank_i;
      if (gs_evt_i) gs_q <= chain_i;
      if (cfg_evt_i) begin
        lat_q   <= chain_i[CFG_LAT_LEN-1:0];
        upper_q <= chain_i[CFG_SR_LEN-1:CFG_LAT_LEN];
      end
    end
  end

  assign gs_o      = gs_q;
  assign cfg_lat_o = lat_q;
  assign cfg_sr_o  = {upper_q, {CFG_LAT_LEN{1'b0}}};
  assign warn_o    = warn_q;
endmodule

// File: rtl/led_shift_router.sv
module led_shift_router #(
  parameter int SR_LEN      = 288,
  parameter int CH_W        = 12,
  parameter int CFG_LAT_LEN = 199,
  parameter int CFG_SR_LEN  = 216
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   ser_clk_i,
  input  logic                                                   ser_din_i,
  input  logic                                                   strobe_i,
  input  logic                                                   blank_i,
  output logic                                                   ser_dout_o,
  output logic [led_sr_pkg::chan_count(SR_LEN, CH_W)-1:0][CH_W-1:0] gs_chan_o,
  output logic [CFG_LAT_LEN-1:0]                                 cfg_lat_o,
  output logic [CFG_SR_LEN-1:0]                                  cfg_sr_o,
  output logic                                                   gs_warn_o
);
  import led_sr_pkg::*;
  localparam int N_CH = chan_count(SR_LEN, CH_W);

  // named internal events, observed by the checker
  logic              sh_evt;
  logic              strb_evt;
  logic              strb_lvl;
  logic              sel_q;
  logic              gs_evt;
  logic              cfg_evt;
  logic [SR_LEN-1:0] sr_q;
  logic [SR_LEN-1:0] gs_q;
  logic              sck_lvl_unused;

  led_edge_sync u_sck_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ser_clk_i),
    .level_o(sck_lvl_unused), .rise_o(sh_evt)
  );

  led_edge_sync u_strb_sync (
    .clk(clk), .rst_n(rst_n), .async_i(strobe_i),
    .level_o(strb_lvl), .rise_o(strb_evt)
  );

  led_shift_core #(.SR_LEN(SR_LEN)) u_core (
    .clk(clk), .rst_n(rst_n), .shift_evt_i(sh_evt), .din_i(ser_din_i),
    .strobe_lvl_i(strb_lvl), .chain_o(sr_q), .sel_o(sel_q)
  );

  assign gs_evt  = strb_evt & ~sel_q;
  assign cfg_evt = strb_evt &  sel_q;

  led_latch_router #(
    .SR_LEN(SR_LEN), .CFG_LAT_LEN(CFG_LAT_LEN), .CFG_SR_LEN(CFG_SR_LEN)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .gs_evt_i(gs_evt), .cfg_evt_i(cfg_evt),
    .blank_i(blank_i), .chain_i(sr_q), .gs_o(gs_q), .cfg_lat_o(cfg_lat_o),
    .cfg_sr_o(cfg_sr_o), .warn_o(gs_warn_o)
  );

  assign ser_dout_o = sr_q[SR_LEN-1];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    assign gs_chan_o[ch] = gs_q[field_lsb(ch, CH_W) +: CH_W];
  end
endmodule

// File: rtl/led_shift_router_chk.sv
module led_shift_router_chk #(
  parameter int SR_LEN      = 288,
  parameter int CFG_LAT_LEN = 199,
  parameter int CFG_SR_LEN  = 216
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sh_evt,
  input logic                   strb_lvl,
  input logic                   sel_q,
  input logic                   gs_evt,
  input logic                   cfg_evt,
  input logic                   blank_i,
  input logic [SR_LEN-1:0]      sr_q,
  input logic [SR_LEN-1:0]      gs_q,
  input logic [CFG_LAT_LEN-1:0] cfg_lat_o,
  input logic [CFG_SR_LEN-1:0]  cfg_sr_o,
  input logic                   gs_warn_o
);
  AST_CHAIN_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    sh_evt |=> sr_q[SR_LEN-1:1] == $past(sr_q[SR_LEN-2:0])); // R2
  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_evt |=> $stable(sr_q)); // R2
  AST_SEL_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    sh_evt |=> sel_q == $past(strb_lvl)); // R3
  AST_SEL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_evt |=> $stable(sel_q)); // R3
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    !(gs_evt && cfg_evt)); // R3
  AST_GS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    gs_evt |=> gs_q == $past(sr_q)); // R4
  AST_GS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !gs_evt |=> $stable(gs_q)); // R5
  AST_CFG_LAT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt |=> cfg_lat_o == $past(sr_q[CFG_LAT_LEN-1:0])); // R5
  AST_CFG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_evt |=> $stable(cfg_lat_o) && $stable(cfg_sr_o)); // R4
  AST_CFG_SR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt |=> cfg_sr_o[CFG_SR_LEN-1:CFG_LAT_LEN] == $past(sr_q[CFG_SR_LEN-1:CFG_LAT_LEN])); // R6
  AST_WARN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (gs_evt && blank_i) |=> gs_warn_o); // R8
  AST_WARN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(gs_evt && blank_i) |=> !gs_warn_o); // R8
endmodule

bind led_shift_router led_shift_router_chk #(
  .SR_LEN(SR_LEN), .CFG_LAT_LEN(CFG_LAT_LEN), .CFG_SR_LEN(CFG_SR_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sh_evt(sh_evt), .strb_lvl(strb_lvl),
  .sel_q(sel_q), .gs_evt(gs_evt), .cfg_evt(cfg_evt), .blank_i(blank_i),
  .sr_q(sr_q), .gs_q(gs_q), .cfg_lat_o(cfg_lat_o), .cfg_sr_o(cfg_sr_o),
  .gs_warn_o(gs_warn_o)
);

// File: tb/led_shift_router_bench.sv
module led_shift_router_bench;
  localparam int LEN = 288;
  localparam int CW  = 12;
  localparam int NC  = 24;
  localparam int CL  = 199;
  localparam int CS  = 216;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, strobe = 1'b0, blank = 1'b0;
  logic ser_dout, warn;
  logic [NC-1:0][CW-1:0] gs_chan;
  logic [CL-1:0] cfg_lat;
  logic [CS-1:0] cfg_sr;

  always #2 clk = ~clk;

  led_shift_router u_led_shift_router (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
    .strobe_i(strobe), .blank_i(blank), .ser_dout_o(ser_dout),
    .gs_chan_o(gs_chan), .cfg_lat_o(cfg_lat), .cfg_sr_o(cfg_sr),
    .gs_warn_o(warn)
  );

  int total = 0, bad = 0;
  int warn_seen = 0, warn_exp = 0;
  logic [LEN-1:0] sr_m = '0, gs_m = '0;
  logic [CL-1:0]  lat_m = '0;
  logic [CS-1:0]  csr_m = '0;
  logic           sel_m = 1'b0;

  always @(negedge clk) if (rst_n && warn) warn_seen++;

  task automatic chk(input logic ok, input string tag, input logic [LEN-1:0] act,
                     input logic [LEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // model: chain shift and remembered level
  task automatic shift_bit(input logic b);
    ser_din = b;
    wait_n(1);
    ser_clk = 1'b1;
    sr_m  = {sr_m[LEN-2:0], b};
    sel_m = strobe;
    wait_n(5);
    ser_clk = 1'b0;
    wait_n(5);
  endtask

  task automatic set_strobe(input logic v);
    if (v && !strobe) begin
      if (!sel_m) begin
        gs_m = sr_m;
        if (blank) warn_exp++;
      end else begin
        lat_m = sr_m[CL-1:0];
        csr_m[CS-1:CL] = sr_m[CS-1:CL];
      end
    end
    strobe = v;
    wait_n(6);
  endtask

  function automatic logic [LEN-1:0] gen_word(input logic [31:0] seed);
    logic [LEN-1:0] w;
    for (int i = 0; i < LEN; i++) begin
      logic [31:0] h;
      h = (i * 32'h9E3779B1) ^ (seed * 32'h85EBCA6B);
      w[i] = ^h[19:8];
    end
    return w;
  endfunction

  // shift a whole word, MSB first; strobe set to lvl just before the last bit
  task automatic send_word(input logic [LEN-1:0] w, input logic lvl);
    for (int i = LEN - 1; i >= 1; i--) shift_bit(w[i]);
    set_strobe(lvl);
    shift_bit(w[0]);
  endtask

  task automatic check_all(input string tag);
    logic ok;
    logic [LEN-1:0] act;
    ok = 1'b1;
    for (int ch = 0; ch < NC; ch++)
      for (int b = 0; b < CW; b++) begin
        act[ch*CW+b] = gs_chan[ch][b];
        if (gs_chan[ch][b] !== gs_m[ch*CW+b]) ok = 1'b0;
      end
    chk(ok, {tag, " R4/R7 channels"}, act, gs_m);
    chk(cfg_lat === lat_m, {tag, " R5 cfg latch"}, LEN'(cfg_lat), LEN'(lat_m));
    chk(cfg_sr === csr_m, {tag, " R6 cfg shift reg"}, LEN'(cfg_sr), LEN'(csr_m));
    chk(warn_seen == warn_exp, {tag, " R8 warn count"}, LEN'(warn_seen), LEN'(warn_exp));
  endtask

  typedef struct packed {
    logic [31:0] seed;
    logic        lvl;
    logic        blk;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h0000_0011, 1'b0, 1'b0},
    '{32'h0000_0A5C, 1'b1, 1'b0},
    '{32'h0001_3377, 1'b0, 1'b1},
    '{32'h00FE_0042, 1'b1, 1'b1},
    '{32'h0BAD_CAFE, 1'b0, 1'b0},
    '{32'h7777_1234, 1'b1, 1'b0}
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [LEN-1:0] w;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(2);
    // R1 reset state
    chk(ser_dout === 1'b0 && warn === 1'b0, "R1 dout/warn", LEN'({ser_dout, warn}), '0);
    chk(gs_chan === '0 && cfg_lat === '0 && cfg_sr === '0, "R1 targets",
        LEN'(gs_chan), '0);

    // table-driven vectors
    foreach (VECS[k]) begin
      w = gen_word(VECS[k].seed);
      blank = VECS[k].blk;
      send_word(w, VECS[k].lvl);
      chk(ser_dout === w[LEN-1], "R2 dout after full word", LEN'(ser_dout), LEN'(w[LEN-1]));
      set_strobe(1'b0);
      set_strobe(1'b1);
      set_strobe(1'b0);
      check_all($sformatf("vec%0d", k));
    end

    // R2 shift-out order: previous word leaves MSB first
    begin
      logic ok;
      logic [LEN-1:0] got;
      ok = 1'b1;
      blank = 1'b0;
      for (int i = 0; i < LEN; i++) begin
        got[LEN-1-i] = ser_dout;
        if (ser_dout !== w[LEN-1-i]) ok = 1'b0;
        shift_bit(1'b0);
      end
      chk(ok, "R2 serial output order", got, w);
    end

    // R3: strobe toggled mid-transfer does not decide; last shift level does
    w = gen_word(32'h55);
    for (int i = LEN - 1; i >= 1; i--) begin
      if (i == 100) set_strobe(1'b1);
      if (i == 90)  set_strobe(1'b0);
      shift_bit(w[i]);
    end
    shift_bit(w[0]);            // strobe low at last shift -> grayscale
    set_strobe(1'b1);
    check_all("R3 low-at-last");
    set_strobe(1'b0);
    // strobe rises again with no new shift: target still grayscale
    blank = 1'b1;
    set_strobe(1'b1);
    set_strobe(1'b0);
    chk(warn_seen == warn_exp, "R3 repeat load keeps target (R8 warn)",
        LEN'(warn_seen), LEN'(warn_exp));
    blank = 1'b0;

    // R7: named channel placement
    w = '0;
    w[11:0]    = 12'hABC;      // R0
    w[23:12]   = 12'h801;      // G0
    w[287:276] = 12'h5E3;      // B7
    send_word(w, 1'b0);
    set_strobe(1'b1);
    set_strobe(1'b0);
    chk(gs_chan[0] === 12'hABC && gs_chan[1] === 12'h801 && gs_chan[23] === 12'h5E3,
        "R7 channel fields", LEN'({gs_chan[23], gs_chan[1], gs_chan[0]}),
        LEN'({12'h5E3, 12'h801, 12'hABC}));

    // R6: boundary bits 198/199/215/216 routed correctly
    w = '0;
    w[198] = 1'b1; w[199] = 1'b1; w[215] = 1'b1; w[216] = 1'b1;
    send_word(w, 1'b1);
    set_strobe(1'b0);
    set_strobe(1'b1);
    set_strobe(1'b0);
    chk(cfg_lat[198] === 1'b1 && cfg_sr[199] === 1'b1 && cfg_sr[215] === 1'b1
        && cfg_sr[198:0] === '0, "R6 boundary bits", LEN'(cfg_sr), LEN'(csr_m));
    check_all("R5 boundary");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule